// File: doc/BRIEF.md
# Compressed Quarter-Wave Sine Synthesizer

This block is a direct digital frequency synthesizer. A 32-bit phase register adds a frequency word on every clock, and the upper 14 bits of the phase are turned into a signed 12-bit sine sample. The output frequency is `ftw_i * f_clk / 2^32`. At a 125 MHz clock one step of the word is about 0.0291 Hz.

Only a quarter period of the wave is described in hardware. The two top phase bits pick the quadrant. The next 12 bits are a first-quadrant angle, split into coarse, mid and fine 4-bit fields. The coarse field reads a 16-entry sine table. The same table, read at the bitwise-complemented index, gives the coarse cosine. The mid field reads a 16-entry table that holds the cosine deficit of the residual angle. The fine and mid fields together form a signed residual angle, and the sine of that angle is taken as linear. Two products merge these terms through sin(a+b) = sin a·cos b + cos a·sin b. The two tables hold 16×12 + 16×11 = 368 bits. Odd quadrants mirror the angle, and the upper half period negates the result.

Top module: `dds_sine_synth`

## Requirements
- R1: On each rising clock edge out of reset, the phase register becomes its old value plus `ftw_i`, modulo 2^32.
- R2: When phase bit 30 is set, the 12-bit angle (phase bits 29:18) is inverted bit by bit before lookup, so the second and fourth quadrants mirror the first.
- R3: When phase bit 31 is set, the sample is the two's-complement negation of the quarter-wave magnitude, so it is zero or negative.
- R4: A phase value held by the phase register appears as its sample on `sample_o` three rising edges later. After reset with a word of 0x4000_0000, the output reads 0 for the first three edges and reaches at least 2045 on the fourth.
- R5: While `rst_ni` is low, the phase and all pipeline stages are zero and `sample_o` reads 0. The first samples after release are therefore 0.
- R6: For a phase P, the sample lies within 2 LSB of round(2048·sin(2π·(P[31:18]+0.5)/16384)), clamped to ±2047.
- R7: `sample_o` never takes the value -2048. Magnitudes saturate at 2047.
- R8: While `ftw_i` is zero, the phase does not move, so `sample_o` stays constant once the pipeline has drained.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ftw_i | input | 32 | Frequency tuning word added to the phase each cycle |
| sample_o | output | 12 | Registered signed sine sample |

## Verification
Every sample is due exactly three rising edges after the phase register holds the matching phase. The bench keeps its own phase model and a three-deep history of it, so each falling-edge comparison uses the phase from three edges back. The reset-release and frozen-word cases are also checked directly, edge by edge, against the three-cycle figure. A full-period sweep with one-angle-step words covers every quadrant and angle code. Random words and constant random words exercise wrap-around.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int PHASE_W  = 32;
  localparam int FIELD_W  = 4;
  localparam int SINE_W   = 12;
  localparam int DEF_W    = 11;
  localparam int OUT_W    = 12;
  localparam int PI_NUM   = 201;  // pi ~= PI_NUM / 2^PI_SHIFT
  localparam int PI_SHIFT = 6;
  localparam real PI_R    = 3.14159265358979;

  // Taylor series; argument never exceeds pi/2 here
  function automatic real sin_series(input real x);
    real term;
    real acc;
    term = x;
    acc  = x;
    for (int n = 1; n < 9; n++) begin
      term = -term * x * x / real'((2 * n) * (2 * n + 1));
      acc  = acc + term;
    end
    return acc;
  endfunction

  function automatic real cos_series(input real x);
    real term;
    real acc;
    term = 1.0;
    acc  = 1.0;
    for (int n = 1; n < 9; n++) begin
      term = -term * x * x / real'((2 * n - 1) * (2 * n));
      acc  = acc + term;
    end
    return acc;
  endfunction
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int PHASE_W = 32,
  parameter int TOP_W   = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] ftw_i,
  output logic [TOP_W-1:0]   phase_top_o
);
  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_q + ftw_i;
  end

  assign phase_top_o = phase_q[PHASE_W-1 -: TOP_W];

  assert_phase_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> phase_q == $past(phase_q) + $past(ftw_i));

  assert_phase_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ftw_i == '0 |=> $stable(phase_q));
endmodule

// File: rtl/dds_quarter_lut.sv
module dds_quarter_lut #(
  parameter int FIELD_W  = 4,
  parameter int SINE_W   = 12,
  parameter int DEF_W    = 11,
  parameter int PI_SHIFT = 6,
  localparam int ANGLE_W = 3 * FIELD_W,
  localparam int RES_W   = 2 * FIELD_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ANGLE_W+1:0]      phase_top_i,
  output logic [SINE_W-1:0]       sin_c_o,
  output logic [SINE_W-1:0]       cos_c_o,
  output logic [DEF_W-1:0]        def_o,
  output logic signed [RES_W-1:0] resid_o,
  output logic                    neg_o
);
  localparam int ENTRIES   = 2 ** FIELD_W;
  localparam int DEF_SHIFT = ANGLE_W + PI_SHIFT + 2;

  // coarse sine sampled at bin centres so that index complement yields cosine
  function automatic int sine_entry(input int i);
    real ang;
    ang = (real'(i) + 0.5) * dds_pkg::PI_R / real'(2 * ENTRIES);
    return int'(real'(2 ** SINE_W) * dds_pkg::sin_series(ang));
  endfunction

  // 1 - cos(r) at the centre of each mid-field block, scaled by 2^DEF_SHIFT
  function automatic int def_entry(input int b);
    real r;
    r = real'(b * ENTRIES + ENTRIES / 2 - ENTRIES * ENTRIES / 2)
        * dds_pkg::PI_R / real'(2 ** (ANGLE_W + 1));
    return int'(real'(2 ** DEF_SHIFT) * (1.0 - dds_pkg::cos_series(r)));
  endfunction

  logic [SINE_W-1:0] sine_rom [ENTRIES];
  logic [DEF_W-1:0]  def_rom  [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_rom
    localparam logic [SINE_W-1:0] SV = SINE_W'(sine_entry(i));
    localparam logic [DEF_W-1:0]  DV = DEF_W'(def_entry(i));
    assign sine_rom[i] = SV;
    assign def_rom[i]  = DV;
  end

  logic [1:0]           quad;
  logic [ANGLE_W-1:0]   folded;
  logic [FIELD_W-1:0]   coarse, mid;
  logic [2*FIELD_W-1:0] low;
  logic [RES_W-1:0]     resid;

  assign quad   = phase_top_i[ANGLE_W+1:ANGLE_W];
  assign folded = phase_top_i[ANGLE_W-1:0] ^ {ANGLE_W{quad[0]}};
  assign coarse = folded[ANGLE_W-1 -: FIELD_W];
  assign mid    = folded[2*FIELD_W-1 -: FIELD_W];
  assign low    = folded[2*FIELD_W-1:0];
  // residual in half-step units relative to coarse bin centre: 2*(low - half) + 1
  assign resid  = {~low[2*FIELD_W-1], low[2*FIELD_W-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sin_c_o <= '0;
      cos_c_o <= '0;
      def_o   <= '0;
      resid_o <= '0;
      neg_o   <= 1'b0;
    end else begin
      sin_c_o <= sine_rom[coarse];
      cos_c_o <= sine_rom[~coarse];
      def_o   <= def_rom[mid];
      resid_o <= $signed(resid);
      neg_o   <= quad[1];
    end
  end
endmodule

// File: rtl/dds_combiner.sv
module dds_combiner #(
  parameter int FIELD_W  = 4,
  parameter int SINE_W   = 12,
  parameter int DEF_W    = 11,
  parameter int OUT_W    = 12,
  parameter int PI_NUM   = 201,
  parameter int PI_SHIFT = 6,
  localparam int RES_W   = 2 * FIELD_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [SINE_W-1:0]       sin_c_i,
  input  logic [SINE_W-1:0]       cos_c_i,
  input  logic [DEF_W-1:0]        def_i,
  input  logic signed [RES_W-1:0] resid_i,
  input  logic                    neg_i,
  output logic signed [OUT_W-1:0] sample_o
);
  localparam int DS    = 3 * FIELD_W + PI_SHIFT + 2;
  localparam int PI_W  = $clog2(PI_NUM + 1) + 1;
  localparam int KPW   = RES_W + PI_W;
  localparam int PDW   = SINE_W + DEF_W;
  localparam int PRW   = SINE_W + 1 + KPW;
  localparam int ACC_W = SINE_W + DS + 3;
  localparam int SH    = SINE_W + DS - (OUT_W - 1);
  localparam logic signed [KPW-1:0]   PI_K = KPW'(PI_NUM);
  localparam logic signed [ACC_W-1:0] RND  = ACC_W'(64'd1 << (SH - 1));
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'd1 << (OUT_W - 1)) - 1);

  logic signed [KPW-1:0] res_scaled;
  assign res_scaled = KPW'(resid_i) * PI_K;

  // stage 2: the two products
  logic [PDW-1:0]        prod_def_q;
  logic signed [PRW-1:0] prod_res_q;
  logic [SINE_W-1:0]     sin_d_q;
  logic                  neg_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_def_q <= '0;
      prod_res_q <= '0;
      sin_d_q    <= '0;
      neg_d_q    <= 1'b0;
    end else begin
      prod_def_q <= PDW'(sin_c_i) * PDW'(def_i);
      prod_res_q <= PRW'($signed({1'b0, cos_c_i})) * PRW'(res_scaled);
      sin_d_q    <= sin_c_i;
      neg_d_q    <= neg_i;
    end
  end

  // stage 3: sum, round, saturate, sign
  logic signed [ACC_W-1:0] lhs, dp, rp, sum_w, shf;
  logic [OUT_W-1:0]        mag;

  assign lhs = $signed({{(ACC_W-SINE_W-DS){1'b0}}, sin_d_q, {DS{1'b0}}});
  assign dp  = $signed({{(ACC_W-PDW){1'b0}}, prod_def_q});
  assign rp  = {{(ACC_W-PRW){prod_res_q[PRW-1]}}, prod_res_q};

  always_comb begin
    sum_w = lhs - dp + rp + RND;
    shf   = sum_w >>> SH;
    if (shf[ACC_W-1])  mag = '0;
    else if (shf > MAXV) mag = MAXV[OUT_W-1:0];
    else               mag = shf[OUT_W-1:0];
  end

  logic signed [OUT_W-1:0] sample_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sample_q <= '0;
    else if (neg_d_q) sample_q <= $signed(-mag);
    else              sample_q <= $signed(mag);
  end

  assign sample_o = sample_q;

  assert_sign_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    neg_d_q |=> sample_o <= 0);

  assert_no_min_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o != {1'b1, {(OUT_W-1){1'b0}}});
endmodule

// File: rtl/dds_sine_synth.sv
module dds_sine_synth #(
  parameter int PHASE_W  = dds_pkg::PHASE_W,
  parameter int FIELD_W  = dds_pkg::FIELD_W,
  parameter int SINE_W   = dds_pkg::SINE_W,
  parameter int DEF_W    = dds_pkg::DEF_W,
  parameter int OUT_W    = dds_pkg::OUT_W,
  parameter int PI_NUM   = dds_pkg::PI_NUM,
  parameter int PI_SHIFT = dds_pkg::PI_SHIFT
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [PHASE_W-1:0]      ftw_i,
  output logic signed [OUT_W-1:0] sample_o
);
  localparam int ANGLE_W = 3 * FIELD_W;
  localparam int TOP_W   = ANGLE_W + 2;
  localparam int RES_W   = 2 * FIELD_W + 1;

  logic [TOP_W-1:0]        phase_top;
  logic [SINE_W-1:0]       sin_c, cos_c;
  logic [DEF_W-1:0]        def_v;
  logic signed [RES_W-1:0] resid;
  logic                    neg;

  dds_phase_acc #(.PHASE_W(PHASE_W), .TOP_W(TOP_W)) i_acc (
    .clk_i, .rst_ni, .ftw_i, .phase_top_o(phase_top)
  );

  dds_quarter_lut #(
    .FIELD_W(FIELD_W), .SINE_W(SINE_W), .DEF_W(DEF_W), .PI_SHIFT(PI_SHIFT)
  ) i_lut (
    .clk_i, .rst_ni, .phase_top_i(phase_top),
    .sin_c_o(sin_c), .cos_c_o(cos_c), .def_o(def_v), .resid_o(resid), .neg_o(neg)
  );

  dds_combiner #(
    .FIELD_W(FIELD_W), .SINE_W(SINE_W), .DEF_W(DEF_W), .OUT_W(OUT_W),
    .PI_NUM(PI_NUM), .PI_SHIFT(PI_SHIFT)
  ) i_comb (
    .clk_i, .rst_ni, .sin_c_i(sin_c), .cos_c_i(cos_c), .def_i(def_v),
    .resid_i(resid), .neg_i(neg), .sample_o
  );
endmodule

// File: tb/test_dds_sine_synth.sv
`timescale 1ns/1ps
module test_dds_sine_synth;
  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic [31:0]        ftw = '0;
  logic signed [11:0] smp;

  dds_sine_synth i_dds_sine_synth (.clk_i(clk), .rst_ni(rst_ni), .ftw_i(ftw), .sample_o(smp));

  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // phase model and 3-deep history (R4 latency)
  logic [31:0] m_ph, h1, h2, h3;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph <= '0; h1 <= '0; h2 <= '0; h3 <= '0;
    end else begin
      h3 <= h2; h2 <= h1; h1 <= m_ph;
      m_ph <= m_ph + ftw;
    end
  end

  function automatic int ref_sample(input logic [31:0] ph);
    real x;
    int  v;
    x = 2.0 * 3.14159265358979 * (real'(ph[31:18]) + 0.5) / 16384.0;
    v = int'(2048.0 * $sin(x));
    if (v > 2047)  v = 2047;
    if (v < -2047) v = -2047;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // continuous comparison against the model, R6 accuracy with quadrant tag
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      int    e;
      int    d;
      string tag;
      e = ref_sample(h3);
      d = int'(smp) - e;
      case (h3[31:30])
        2'd0:    tag = "R6,R1 q0";
        2'd1:    tag = "R6,R2 q1";
        2'd2:    tag = "R6,R3 q2";
        default: tag = "R6,R2,R3 q3";
      endcase
      check(d <= 2 && d >= -2, tag, int'(smp), e);
      check(smp != -12'sd2048, "R7 no -2048", int'(smp), -2047);
    end
  end

  initial begin
    logic signed [11:0] held;
    void'($urandom(32'h5eed_1234));
    // R5: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(smp == 0, "R5 reset output", int'(smp), 0);
    // R4: release with a quarter-turn word
    ftw = 32'h4000_0000;
    rst_ni = 1'b1;
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      check(smp == 0, "R4/R5 pipeline zero", int'(smp), 0);
    end
    @(negedge clk);
    check(smp >= 2045, "R4 first sample at edge 4", int'(smp), 2047);
    repeat (40) @(negedge clk);
    // full sweep, one angle step per clock
    ftw = 32'h0004_0000;
    repeat (16384) @(negedge clk);
    // R8: frozen word
    ftw = '0;
    repeat (4) @(negedge clk);
    held = smp;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(smp == held, "R8 frozen output", int'(smp), int'(held));
    end
    // random words every cycle
    for (int i = 0; i < 4000; i++) begin
      ftw = $urandom;
      @(negedge clk);
    end
    // constant random words
    for (int s = 0; s < 20; s++) begin
      ftw = $urandom;
      repeat (200) @(negedge clk);
    end
    // R5: reset in mid run
    rst_ni = 1'b0;
    @(negedge clk);
    check(smp == 0, "R5 mid-run reset", int'(smp), 0);
    ftw = 32'h8004_0000;
    rst_ni = 1'b1;
    repeat (300) @(negedge clk);
    finish_run();
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule